// File: doc/BRIEF.md
# Two-Pass Streaming Sector Single-Error Corrector

This unit protects a 512-bit sector with a 10-bit single-error-correcting Hamming-style code. It sits in a page memory read path and never holds a copy of the sector. When a sector is written, the data streams through the unit once, unchanged, and the unit appends the check value. When a sector is read, the sense side sends the same sector and its check bits twice. The first pass only accumulates a syndrome. The second pass forwards the data bytes and inverts the one faulty bit on the fly.

Data moves one byte per beat on a valid/ready input stream and a valid/ready output stream. Three single-cycle strobes select the operation: encode, pass 1 (syndrome) and pass 2 (fix). Between passes the unit keeps only the syndrome, a beat counter and a bit-position counter. Three sticky flags report the result.

The controller has seven states. IDLE leaves both streams closed. ENC_DATA forwards data beats and moves to ENC_CHK after the last data beat. ENC_CHK emits the check beats and returns to IDLE after the last one. SYN_DATA absorbs data beats and moves to SYN_CHK. SYN_CHK absorbs the check beats, latches the result and returns to IDLE. FIX_DATA forwards corrected data beats and moves to FIX_CHK. FIX_CHK absorbs the check beats and returns to IDLE. A strobe moves any state directly to the first state of its operation.

Top module: `sector_sec_stream`

## Requirements
- R1: Encode. The 64 data beats are forwarded unchanged. They are followed by two output beats: the first carries check[7:0], the second carries check[9:8] in bits 1:0 with bits 7:2 zero. Data bit d is bit d%8 of beat d/8. Its position is the d-th integer from 3 upward that is not a power of two. The check value is the XOR of the positions of all set data bits.
- R2: Pass 1 accepts 66 beats (64 data beats, then the two check beats in the layout of R1) with in_ready high regardless of out_ready, and produces no output. Bits 7:2 of the second check beat have no effect.
- R3: If the syndrome (the stored check XOR the recomputed check) is zero, both flags stay 0 and pass 2 outputs the data unchanged.
- R4: If exactly one data bit is wrong, err_fixed is 1 after pass 1, and pass 2 outputs the 64 data beats with that bit restored.
- R5: If exactly one check bit is wrong (a power-of-two syndrome), err_fixed is 1 and pass 2 leaves the data unchanged.
- R6: A syndrome above 522 sets err_uncorr, leaves err_fixed at 0, and pass 2 forwards the data unchanged.
- R7: err_fixed and err_uncorr are set when pass 1 ends. done is set when pass 2 ends and when an encode ends. All three flags hold until the next pass-1 or encode strobe, which clears them. A pass-2 strobe leaves them unchanged.
- R8: Counters advance only on beats where valid and ready are both high. In ENC_DATA and FIX_DATA, in_ready follows out_ready, so a stalled output holds the input.
- R9: In a strobe cycle no beat moves on either stream. A strobe restarts the unit. When strobes coincide, pass 1 wins over encode, which wins over pass 2.
- R10: After reset, in_ready, out_valid and all flags are 0.
- R11: Pass 2 does not change the syndrome, so repeating pass 2 gives the same corrected output again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_enc | input | 1 | Strobe: begin an encode |
| start_syn | input | 1 | Strobe: begin pass 1 (syndrome) |
| start_fix | input | 1 | Strobe: begin pass 2 (correction) |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts output |
| out_data | output | 8 | Output byte |
| err_fixed | output | 1 | Single error found (data or check bit) |
| err_uncorr | output | 1 | Syndrome points outside the codeword |
| done | output | 1 | Pass 2 or encode finished |

## Verification
The hardest situation to reach from the ports is a syndrome that names no position inside the codeword. Random single-bit faults never produce it. The stimulus therefore builds it on purpose in two ways. One is to invert all ten stored check bits, which gives a syndrome of 1023. The other is to corrupt the two data bits at positions 3 and 520, which gives 523. In both cases the bench then confirms that pass 2 forwards the corrupted bytes untouched. The random handshake throttles both streams, so correction must land on the right bit even while the position counter pauses mid-sector.

// File: rtl/secc_pkg.sv
package secc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ENC_DATA,
        ST_ENC_CHK,
        ST_SYN_DATA,
        ST_SYN_CHK,
        ST_FIX_DATA,
        ST_FIX_CHK
    } secc_state_e;

    // true for 1, 2, 4, 8, ...
    function automatic logic is_pow2(input logic [15:0] v);
        return (v != 16'd0) && ((v & (v - 16'd1)) == 16'd0);
    endfunction

    // next codeword position that carries data (skips check-bit slots)
    function automatic logic [15:0] step_pos(input logic [15:0] p);
        logic [15:0] q;
        q = p + 16'd1;
        if (is_pow2(q)) q = q + 16'd1;
        return q;
    endfunction

endpackage

// File: rtl/secc_posgen.sv
module secc_posgen
    import secc_pkg::*;
#(
    parameter int BEAT_W = 8,
    parameter int CHK_W  = 10
) (
    input  logic [CHK_W-1:0]             base,
    output logic [BEAT_W-1:0][CHK_W-1:0] lane_pos,
    output logic [CHK_W-1:0]             next_base
);

    always_comb begin
        logic [CHK_W-1:0] p;
        p = base;
        for (int i = 0; i < BEAT_W; i++) begin
            lane_pos[i] = p;
            p = CHK_W'(step_pos(16'(p)));
        end
        next_base = p;
    end

endmodule

// File: rtl/secc_lane_fold.sv
module secc_lane_fold #(
    parameter int BEAT_W = 8,
    parameter int CHK_W  = 10
) (
    input  logic [BEAT_W-1:0]            beat,
    input  logic [BEAT_W-1:0][CHK_W-1:0] lane_pos,
    input  logic [CHK_W-1:0]             syn,
    input  logic                         fix_on,
    output logic [CHK_W-1:0]             par,
    output logic [BEAT_W-1:0]            flip
);

    for (genvar g = 0; g < BEAT_W; g++) begin : g_lane
        assign flip[g] = fix_on && (lane_pos[g] == syn);
    end

    always_comb begin
        par = '0;
        for (int i = 0; i < BEAT_W; i++) begin
            if (beat[i]) par = par ^ lane_pos[i];
        end
    end

endmodule

// File: rtl/sector_sec_stream.sv
module sector_sec_stream
    import secc_pkg::*;
#(
    parameter int DATA_BITS = 512,
    parameter int BEAT_W    = 8,
    parameter int CHK_W     = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_enc,
    input  logic              start_syn,
    input  logic              start_fix,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BEAT_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BEAT_W-1:0] out_data,
    output logic              err_fixed,
    output logic              err_uncorr,
    output logic              done
);

    localparam int DATA_BEATS = DATA_BITS / BEAT_W;
    localparam int CHK_BEATS  = (CHK_W + BEAT_W - 1) / BEAT_W;
    localparam int CPAD       = CHK_BEATS * BEAT_W;
    localparam int CNT_W      = $clog2(DATA_BEATS);
    localparam int MAX_POS    = DATA_BITS + CHK_W;
    localparam logic [CHK_W-1:0] MAX_POS_V  = CHK_W'(MAX_POS);
    localparam logic [CHK_W-1:0] FIRST_POS  = CHK_W'(3);
    localparam logic [CNT_W-1:0] LAST_DATA  = CNT_W'(DATA_BEATS - 1);
    localparam logic [CNT_W-1:0] LAST_CHK   = CNT_W'(CHK_BEATS - 1);

    secc_state_e             state, state_nx;
    logic [CNT_W-1:0]        cnt;
    logic [CHK_W-1:0]        pos_base, pos_next;
    logic [CHK_W-1:0]        acc, par, syn_final, chk_in;
    logic [BEAT_W-1:0][CHK_W-1:0] lane_pos;
    logic [BEAT_W-1:0]       flip;
    logic [CPAD-1:0]         chk_in_pad, chk_out_pad;
    logic                    fix_en, any_start, in_fire, out_fire;
    logic                    is_data_st, last_data, last_chk;

    secc_posgen #(.BEAT_W(BEAT_W), .CHK_W(CHK_W)) posgen_i (
        .base      (pos_base),
        .lane_pos  (lane_pos),
        .next_base (pos_next)
    );

    secc_lane_fold #(.BEAT_W(BEAT_W), .CHK_W(CHK_W)) fold_i (
        .beat     (in_data),
        .lane_pos (lane_pos),
        .syn      (acc),
        .fix_on   (fix_en && (state == ST_FIX_DATA)),
        .par      (par),
        .flip     (flip)
    );

    assign any_start   = start_enc || start_syn || start_fix;
    assign in_fire     = in_valid && in_ready;
    assign out_fire    = out_valid && out_ready;
    assign last_data   = (cnt == LAST_DATA);
    assign last_chk    = (cnt == LAST_CHK);
    assign is_data_st  = (state == ST_ENC_DATA) || (state == ST_SYN_DATA) ||
                         (state == ST_FIX_DATA);
    assign chk_in_pad  = CPAD'(in_data) << (BEAT_W * cnt);
    assign chk_in      = chk_in_pad[CHK_W-1:0];
    assign syn_final   = acc ^ chk_in;
    assign chk_out_pad = CPAD'(acc) >> (BEAT_W * cnt);

    // next-state logic
    always_comb begin
        state_nx = state;
        if (start_syn)      state_nx = ST_SYN_DATA;
        else if (start_enc) state_nx = ST_ENC_DATA;
        else if (start_fix) state_nx = ST_FIX_DATA;
        else begin
            unique case (state)
                ST_IDLE:     state_nx = ST_IDLE;
                ST_ENC_DATA: if (in_fire && last_data)  state_nx = ST_ENC_CHK;
                ST_ENC_CHK:  if (out_fire && last_chk)  state_nx = ST_IDLE;
                ST_SYN_DATA: if (in_fire && last_data)  state_nx = ST_SYN_CHK;
                ST_SYN_CHK:  if (in_fire && last_chk)   state_nx = ST_IDLE;
                ST_FIX_DATA: if (in_fire && last_data)  state_nx = ST_FIX_CHK;
                ST_FIX_CHK:  if (in_fire && last_chk)   state_nx = ST_IDLE;
                default:     state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // stream outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = in_data;
        unique case (state)
            ST_IDLE: ;
            ST_ENC_DATA: begin
                in_ready  = out_ready;
                out_valid = in_valid;
            end
            ST_ENC_CHK: begin
                out_valid = 1'b1;
                out_data  = chk_out_pad[BEAT_W-1:0];
            end
            ST_SYN_DATA, ST_SYN_CHK, ST_FIX_CHK: in_ready = 1'b1;
            ST_FIX_DATA: begin
                in_ready  = out_ready;
                out_valid = in_valid;
                out_data  = in_data ^ flip;
            end
            default: ;
        endcase
        if (any_start) begin
            in_ready  = 1'b0;
            out_valid = 1'b0;
        end
    end

    // counters, syndrome and flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            pos_base   <= FIRST_POS;
            acc        <= '0;
            fix_en     <= 1'b0;
            err_fixed  <= 1'b0;
            err_uncorr <= 1'b0;
            done       <= 1'b0;
        end else if (start_syn || start_enc) begin
            cnt        <= '0;
            pos_base   <= FIRST_POS;
            acc        <= '0;
            fix_en     <= 1'b0;
            err_fixed  <= 1'b0;
            err_uncorr <= 1'b0;
            done       <= 1'b0;
        end else if (start_fix) begin
            cnt      <= '0;
            pos_base <= FIRST_POS;
        end else begin
            if (in_fire || (state == ST_ENC_CHK && out_fire)) begin
                if ((is_data_st && last_data) || (!is_data_st && last_chk))
                    cnt <= '0;
                else
                    cnt <= cnt + 1'b1;
            end
            if (in_fire && is_data_st)
                pos_base <= pos_next;
            if (in_fire && (state == ST_ENC_DATA || state == ST_SYN_DATA))
                acc <= acc ^ par;
            if (in_fire && state == ST_SYN_CHK) begin
                acc <= syn_final;
                if (last_chk) begin
                    err_fixed  <= (syn_final != '0) && (syn_final <= MAX_POS_V);
                    err_uncorr <= (syn_final > MAX_POS_V);
                    fix_en     <= (syn_final != '0) && (syn_final <= MAX_POS_V) &&
                                  !is_pow2(16'(syn_final));
                end
            end
            if ((state == ST_ENC_CHK && out_fire && last_chk) ||
                (state == ST_FIX_CHK && in_fire && last_chk))
                done <= 1'b1;
        end
    end

    AST_FLIP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flip)); // R4
    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_fixed && err_uncorr)); // R6
    AST_UNCORR_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (err_uncorr && out_valid) |-> (out_data == in_data)); // R6
    AST_ENC_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ENC_DATA && out_valid) |-> (out_data == in_data)); // R1
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_syn && !start_enc && state != ST_SYN_CHK)
        |=> $stable({err_fixed, err_uncorr})); // R7
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start_syn && !start_enc) |=> done); // R7
    AST_POS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        is_data_st |-> (pos_base <= MAX_POS_V)); // R2

endmodule

// File: tb/sector_sec_stream_tb_top.sv
module sector_sec_stream_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_enc = 1'b0, start_syn = 1'b0, start_fix = 1'b0;
    logic       in_valid = 1'b0, out_ready = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready, out_valid, err_fixed, err_uncorr, done;
    logic [7:0] out_data;

    int total = 0;
    int bad   = 0;

    logic [7:0] src      [0:65];
    logic [7:0] exp_data [0:63];
    logic [7:0] got      [0:65];
    int         pos_tab  [0:511];
    int         n_got;
    int         n_idx;

    always #2 clk = ~clk;

    sector_sec_stream dut_i (
        .clk(clk), .rst_n(rst_n),
        .start_enc(start_enc), .start_syn(start_syn), .start_fix(start_fix),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .err_fixed(err_fixed), .err_uncorr(err_uncorr), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [9:0] calc_chk();
        logic [9:0] c = '0;
        for (int d = 0; d < 512; d++)
            if (src[d/8][d%8]) c ^= 10'(pos_tab[d]);
        return c;
    endfunction

    task automatic fill(input int kind);   // 0 random, 1 zeros, 2 ones
        logic [9:0] c;
        for (int b = 0; b < 64; b++)
            src[b] = (kind == 1) ? 8'h00 : (kind == 2) ? 8'hFF : 8'($urandom);
        c = calc_chk();
        src[64] = c[7:0];
        src[65] = {6'b0, c[9:8]};
        for (int b = 0; b < 64; b++) exp_data[b] = src[b];
    endtask

    task automatic strobe(input logic e, input logic s, input logic f);
        @(negedge clk);
        start_enc = e; start_syn = s; start_fix = f;
        in_valid = 1'b1; out_ready = 1'b1;
        #1;
        check(!in_ready && !out_valid, "R9 strobe cycle quiet",
              int'({in_ready, out_valid}), 0);
        @(negedge clk);
        start_enc = 1'b0; start_syn = 1'b0; start_fix = 1'b0;
        in_valid = 1'b0; out_ready = 1'b0;
    endtask

    task automatic stream(input int n_in, input int n_out, input int vp, input int rp);
        int cyc = 0;
        n_idx = 0; n_got = 0;
        while ((n_idx < n_in || n_got < n_out) && cyc < 3000) begin
            in_valid  = (n_idx < n_in) && (($urandom % 100) < vp);
            in_data   = in_valid ? src[n_idx] : 8'($urandom);
            out_ready = (($urandom % 100) < rp);
            #1;
            if (in_valid && in_ready) n_idx++;
            if (out_valid && out_ready) begin
                if (n_got < 66) got[n_got] = out_data;
                n_got++;
            end
            @(negedge clk);
            cyc++;
        end
        in_valid = 1'b0; out_ready = 1'b0;
        check(cyc < 3000, "R8 stream finished", cyc, 3000);
    endtask

    function automatic int first_diff();
        for (int b = 0; b < 64; b++)
            if (got[b] != exp_data[b]) return b;
        return -1;
    endfunction

    task automatic decode(input bit e_fix, input bit e_unc, input string req);
        strobe(1'b0, 1'b1, 1'b0);
        stream(66, 0, 40 + int'($urandom % 61), int'($urandom % 100));
        check(n_got == 0, {req, " R2 pass1 silent"}, n_got, 0);
        check(err_fixed == e_fix, {req, " err_fixed"}, int'(err_fixed), int'(e_fix));
        check(err_uncorr == e_unc, {req, " err_uncorr"}, int'(err_uncorr), int'(e_unc));
        check(!done, {req, " R7 done low after pass1"}, int'(done), 0);
        strobe(1'b0, 1'b0, 1'b1);
        stream(66, 64, 40 + int'($urandom % 61), 40 + int'($urandom % 61));
        check(n_got == 64 && first_diff() < 0, {req, " pass2 data"},
              first_diff() < 0 ? n_got : int'(got[first_diff()]),
              first_diff() < 0 ? 64 : int'(exp_data[first_diff()]));
        check(done && err_fixed == e_fix, {req, " R7 done and flags after pass2"},
              int'({done, err_fixed}), int'({1'b1, e_fix}));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=expired expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int p;
        void'($urandom(32'd4242));
        p = 3;
        for (int d = 0; d < 512; d++) begin
            pos_tab[d] = p;
            p++;
            if ((p & (p - 1)) == 0) p++;
        end

        repeat (3) @(negedge clk);
        #1;
        check(!in_ready && !out_valid && !err_fixed && !err_uncorr && !done,
              "R10 reset state", int'({in_ready, out_valid, err_fixed, err_uncorr, done}), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 encode: zeros, ones, random
        for (int k = 0; k < 5; k++) begin
            fill(k < 2 ? k + 1 : 0);
            strobe(1'b1, 1'b0, 1'b0);
            stream(64, 66, 50 + int'($urandom % 51), 50 + int'($urandom % 51));
            check(n_got == 66 && first_diff() < 0, "R1 encode data passthrough",
                  n_got, 66);
            check(got[64] == src[64] && got[65] == src[65], "R1 encode check beats",
                  int'({got[65], got[64]}), int'({src[65], src[64]}));
            check(done && !err_fixed && !err_uncorr, "R7 done after encode",
                  int'({done, err_fixed, err_uncorr}), 4);
        end

        // R3 clean codeword
        fill(0);
        decode(1'b0, 1'b0, "R3 clean");

        // R2 ignored upper bits of second check beat
        fill(0);
        src[65] = src[65] | 8'hFC;
        decode(1'b0, 1'b0, "R2 upper check bits ignored");

        // R4 single data-bit errors: directed corners then random
        for (int k = 0; k < 14; k++) begin
            int d;
            fill(0);
            case (k)
                0: d = 0;   1: d = 7;   2: d = 8;
                3: d = 504; 4: d = 511;
                default: d = int'($urandom % 512);
            endcase
            src[d/8][d%8] = ~src[d/8][d%8];
            decode(1'b1, 1'b0, "R4 data bit error");
        end

        // R11 repeat pass 2 after the last correction; flags untouched by start_fix
        strobe(1'b0, 1'b0, 1'b1);
        stream(66, 64, 70, 70);
        check(n_got == 64 && first_diff() < 0, "R11 second pass2 corrected",
              n_got, 64);
        check(err_fixed && !err_uncorr, "R7 flags kept over pass2 strobe",
              int'({err_fixed, err_uncorr}), 2);

        // R5 each check bit in error
        for (int k = 0; k < 10; k++) begin
            fill(0);
            src[64 + k/8][k%8] = ~src[64 + k/8][k%8];
            decode(1'b1, 1'b0, "R5 check bit error");
        end

        // R6 syndrome 1023: all stored check bits inverted
        fill(0);
        src[64] = ~src[64];
        src[65] = src[65] ^ 8'h03;
        decode(1'b0, 1'b1, "R6 syndrome 1023");

        // R6 syndrome 523: data at positions 3 and 520
        fill(0);
        for (int d = 0; d < 512; d++)
            if (pos_tab[d] == 3 || pos_tab[d] == 520) src[d/8][d%8] = ~src[d/8][d%8];
        for (int b = 0; b < 64; b++) exp_data[b] = src[b];
        decode(1'b0, 1'b1, "R6 syndrome 523");

        // R8 stall in pass 2: out_ready low holds input
        strobe(1'b0, 1'b0, 1'b1);
        in_valid = 1'b1; out_ready = 1'b0; in_data = src[0];
        #1;
        check(!in_ready && out_valid, "R8 stall holds input",
              int'({in_ready, out_valid}), 1);
        @(negedge clk);
        in_valid = 1'b0;

        // R9 priority: all strobes together select pass 1
        strobe(1'b1, 1'b1, 1'b1);
        out_ready = 1'b0;
        #1;
        check(in_ready && !out_valid, "R9 pass1 wins priority",
              int'({in_ready, out_valid}), 2);
        @(negedge clk);

        // R9 restart mid-pass then clean decode
        fill(0);
        strobe(1'b0, 1'b1, 1'b0);
        stream(10, 0, 100, 100);
        decode(1'b0, 1'b0, "R9 restart");

        // mixed random
        for (int k = 0; k < 16; k++) begin
            fill(0);
            if ($urandom % 2) begin
                int d = int'($urandom % 512);
                src[d/8][d%8] = ~src[d/8][d%8];
                decode(1'b1, 1'b0, "R4 random error");
            end else begin
                decode(1'b0, 1'b0, "R3 random clean");
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule